// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block is the digital power-mode controller of an energy-harvesting radio system-on-chip. It watches two supply comparator flags, one for the turn-on threshold and one for the turn-off threshold. It also receives the reset sources (hardware pin, software command, watchdog and flywheel timer time-outs), the wake events (CPU timer, external interrupt, short-term timer, active-low wake pins) and a sleep request from the CPU that names a target mode.

From these inputs it tracks six modes: OFF, CPU, Standby, ShortTerm Sleep, Flywheel Sleep and Deep Sleep. Each wake-up is resolved by its source and by the current mode:
- Standby resumes with all state kept.
- ShortTerm Sleep resumes with the CPU context kept but the radio configuration flagged as lost.
- Flywheel Sleep and Deep Sleep leave only through a full supply-on reset.

The outputs are:
- a fixed-length supply-on reset pulse;
- the CPU clock-source select;
- the CPU stop signal and the domain power enables;
- the retained-RAM supply select;
- the radio-configuration-lost flag;
- the threshold status pin, as a level and an output enable.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `sup_above_off` is low, the mode is OFF (code 0) on the next cycle and no reset pulse is active. From OFF, the block leaves only when `sup_above_on` is high. That exit enters CPU mode (code 1) and starts a supply-on reset. Reset sources are ignored while in OFF.
- R2: In any mode other than OFF, with the supply above turn-off, a high `hw_rst_pin`, `sw_rst_cmd`, `wdt_expire` or `fly_expire` starts a supply-on reset and sets the mode to CPU on the next cycle.
- R3: `sor_pulse` goes high on the cycle after the last triggering cycle and stays high for exactly SOR_LEN cycles (default 4). After any supply-on reset, `clk_sel_xto` is 0 (internal RC oscillator) and `radio_cfg_lost` is 0 (default configuration).
- R4: In Standby (code 2), `cpu_tmr_wake` or `ext_irq_wake` returns the mode to CPU, and `clk_sel_xto` keeps its value.
- R5: In ShortTerm Sleep (code 3), `st_expire` returns the mode to CPU with `clk_sel_xto`=0 and `radio_cfg_lost`=1. In CPU mode, `radio_cfg_done` clears `radio_cfg_lost`.
- R6: In Flywheel Sleep (code 4) and Deep Sleep (code 5), any low bit of `wake_pin_n` starts a supply-on reset. The wake pins are ignored in the other modes. Standby wake events and `st_expire` are ignored in modes that do not use them.
- R7: `dig_pwr_en` is high only in CPU and Standby, and `ram_on_aon` is its inverse. `fly_pwr_en` is high in CPU, Standby, ShortTerm and Flywheel. `cpu_stop` is high in every mode except CPU, and also while `sor_pulse` is high.
- R8: A `sleep_req` with `sleep_code` 2, 3, 4 or 5 is accepted only in CPU mode. The mode equals the code on the next cycle.
- R9: A sleep request made while `sor_pulse` is high is ignored: the mode stays CPU and `req_err` stays low.
- R10: A sleep request in CPU mode with an undefined code (0, 1, 6 or 7) leaves the mode unchanged. It raises `req_err` for exactly one cycle, on the next cycle.
- R11: `thr_pin_oe` is low from reset until `sup_above_on` is first seen high. It is also low whenever `sup_above_off` is low, and it stays low after that until `sup_above_on` is high again. While `thr_pin_oe` is high, `thr_pin_o` follows `sup_above_on`. Both outputs are registered, one cycle after the flags.
- R12: `clk_sel_xto` changes to 1 only in CPU mode, outside a reset pulse, when `xto_req` and `xto_ready` are both high. Entering ShortTerm Sleep returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| sup_above_on | input | 1 | Supply is above the turn-on threshold |
| sup_above_off | input | 1 | Supply is above the turn-off threshold |
| hw_rst_pin | input | 1 | Active-high hardware reset pin |
| sw_rst_cmd | input | 1 | Software reset command |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| fly_expire | input | 1 | Flywheel timer time-out pulse |
| st_expire | input | 1 | Short-term timer time-out pulse |
| cpu_tmr_wake | input | 1 | CPU timer wake event |
| ext_irq_wake | input | 1 | External interrupt wake event |
| wake_pin_n | input | NWAKE | Active-low wake pins |
| sleep_req | input | 1 | Sleep request strobe |
| sleep_code | input | 3 | Target mode code of the request |
| xto_req | input | 1 | CPU asks to run from the crystal oscillator |
| xto_ready | input | 1 | Crystal oscillator is stable |
| radio_cfg_done | input | 1 | CPU has re-initialised the radio configuration |
| mode_o | output | 3 | Current mode code (0 OFF … 5 Deep) |
| sor_pulse | output | 1 | Supply-on reset pulse |
| clk_sel_xto | output | 1 | CPU clock select: 1 crystal, 0 internal RC |
| cpu_stop | output | 1 | CPU clock stopped or held |
| dig_pwr_en | output | 1 | Main digital domain power enable |
| fly_pwr_en | output | 1 | Flywheel timer domain power enable |
| ram_on_aon | output | 1 | Retained RAM supplied from the always-on domain |
| radio_cfg_lost | output | 1 | Radio and synthesizer configuration invalid |
| thr_pin_o | output | 1 | Threshold status pin level |
| thr_pin_oe | output | 1 | Threshold status pin output enable |
| req_err | output | 1 | One-cycle flag for an undefined request code |

## Verification
Each sleep mode is entered in turn, and every wake source is applied to each one. Applying the sources that a mode does not use shows that the block ignores them. Applying the source that a mode does use shows which kind of exit the mode takes: a resume with state kept, a resume with the radio configuration lost, or a full reset. Supply ramps are driven in three patterns (above turn-off only, above turn-on, then a dip back below turn-off); together they separate OFF exit from threshold pin tri-state. A reset source held for several cycles shows that the pulse length is counted from the last trigger. Requests made during the pulse and requests with undefined codes separate the ignore path from the error path.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    PM_OFF   = 3'd0,
    PM_CPU   = 3'd1,
    PM_STBY  = 3'd2,
    PM_SHORT = 3'd3,
    PM_FLY   = 3'd4,
    PM_DEEP  = 3'd5
  } pm_mode_e;

  // legal sleep targets are Standby through Deep
  function automatic logic pm_code_valid(input logic [2:0] code);
    return (code >= 3'd2) && (code <= 3'd5);
  endfunction

  function automatic logic pm_dig_on(input pm_mode_e m);
    return (m == PM_CPU) || (m == PM_STBY);
  endfunction

  function automatic logic pm_fly_on(input pm_mode_e m);
    return (m == PM_CPU) || (m == PM_STBY) || (m == PM_SHORT) || (m == PM_FLY);
  endfunction

  // modes whose exit through the wake pins is a full reset
  function automatic logic pm_wake_pin_mode(input pm_mode_e m);
    return (m == PM_FLY) || (m == PM_DEEP);
  endfunction

endpackage

// File: rtl/pms_supply_mon.sv
module pms_supply_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on,
  input  logic sup_above_off,
  output logic off_now,
  output logic thr_pin_o,
  output logic thr_pin_oe
);
  logic seen_on_q;
  logic seen_on_d;

  assign off_now   = !sup_above_off;
  assign seen_on_d = sup_above_off && (seen_on_q || sup_above_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_on_q  <= 1'b0;
      thr_pin_oe <= 1'b0;
      thr_pin_o  <= 1'b0;
    end else begin
      seen_on_q  <= seen_on_d;
      thr_pin_oe <= seen_on_d;
      thr_pin_o  <= sup_above_on;
    end
  end
endmodule

// File: rtl/pms_sor_gen.sv
module pms_sor_gen #(
  parameter int SOR_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_now,
  input  logic sor_trig,
  output logic sor_active
);
  localparam int CW = $clog2(SOR_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(SOR_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (off_now)         cnt_q <= '0;
    else if (sor_trig)        cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign sor_active = (cnt_q != '0);
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pms_pkg::*;
#(
  parameter int NWAKE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_now,
  input  logic             sup_above_on,
  input  logic             sor_active,
  input  logic             hw_rst_pin,
  input  logic             sw_rst_cmd,
  input  logic             wdt_expire,
  input  logic             fly_expire,
  input  logic             st_expire,
  input  logic             cpu_tmr_wake,
  input  logic             ext_irq_wake,
  input  logic [NWAKE-1:0] wake_pin_n,
  input  logic             sleep_req,
  input  logic [2:0]       sleep_code,
  input  logic             xto_req,
  input  logic             xto_ready,
  input  logic             radio_cfg_done,
  output pm_mode_e         mode_q,
  output logic             sor_trig,
  output logic             wake_keep,
  output logic             wake_st,
  output logic             req_accept,
  output logic             req_bad,
  output logic             clk_sel_xto,
  output logic             radio_cfg_lost,
  output logic             req_err
);
  pm_mode_e mode_d;
  logic any_wake, rst_src, por_exit, busy, req_try, cpu_free, xto_set, xto_clr;

  always_comb begin
    any_wake = |(~wake_pin_n);
    rst_src  = hw_rst_pin || sw_rst_cmd || wdt_expire || fly_expire;
    por_exit = (mode_q == PM_OFF) && sup_above_on;
    sor_trig = !off_now && (por_exit ||
               ((mode_q != PM_OFF) && (rst_src || (any_wake && pm_wake_pin_mode(mode_q)))));
    busy      = off_now || sor_trig;
    cpu_free  = !busy && (mode_q == PM_CPU) && !sor_active;
    wake_keep = !busy && (mode_q == PM_STBY) && (cpu_tmr_wake || ext_irq_wake);
    wake_st   = !busy && (mode_q == PM_SHORT) && st_expire;
    req_try    = cpu_free && sleep_req;
    req_accept = req_try && pm_code_valid(sleep_code);
    req_bad    = req_try && !pm_code_valid(sleep_code);

    mode_d = mode_q;
    if (off_now)                              mode_d = PM_OFF;
    else if (sor_trig || wake_keep || wake_st) mode_d = PM_CPU;
    else if (req_accept)                      mode_d = pm_mode_e'(sleep_code);

    xto_clr = busy || wake_st || (req_accept && (sleep_code == 3'(PM_SHORT)));
    xto_set = cpu_free && xto_req && xto_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q         <= PM_OFF;
      clk_sel_xto    <= 1'b0;
      radio_cfg_lost <= 1'b0;
      req_err        <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      req_err <= req_bad;
      if (xto_clr)      clk_sel_xto <= 1'b0;
      else if (xto_set) clk_sel_xto <= 1'b1;
      if (busy)                                   radio_cfg_lost <= 1'b0;
      else if (wake_st)                           radio_cfg_lost <= 1'b1;
      else if ((mode_q == PM_CPU) && radio_cfg_done) radio_cfg_lost <= 1'b0;
    end
  end
endmodule

// File: rtl/pms_dom_ctrl.sv
module pms_dom_ctrl
  import pms_pkg::*;
(
  input  pm_mode_e mode,
  input  logic     sor_active,
  output logic     cpu_stop,
  output logic     dig_pwr_en,
  output logic     fly_pwr_en,
  output logic     ram_on_aon
);
  always_comb begin
    dig_pwr_en = pm_dig_on(mode);
    fly_pwr_en = pm_fly_on(mode);
    ram_on_aon = !pm_dig_on(mode);
    cpu_stop   = (mode != PM_CPU) || sor_active;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int SOR_LEN = 4,
  parameter int NWAKE   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_above_on,
  input  logic             sup_above_off,
  input  logic             hw_rst_pin,
  input  logic             sw_rst_cmd,
  input  logic             wdt_expire,
  input  logic             fly_expire,
  input  logic             st_expire,
  input  logic             cpu_tmr_wake,
  input  logic             ext_irq_wake,
  input  logic [NWAKE-1:0] wake_pin_n,
  input  logic             sleep_req,
  input  logic [2:0]       sleep_code,
  input  logic             xto_req,
  input  logic             xto_ready,
  input  logic             radio_cfg_done,
  output logic [2:0]       mode_o,
  output logic             sor_pulse,
  output logic             clk_sel_xto,
  output logic             cpu_stop,
  output logic             dig_pwr_en,
  output logic             fly_pwr_en,
  output logic             ram_on_aon,
  output logic             radio_cfg_lost,
  output logic             thr_pin_o,
  output logic             thr_pin_oe,
  output logic             req_err
);
  // named internal events, visible to the checker
  logic     off_now, sor_trig, sor_active;
  logic     wake_keep, wake_st, req_accept, req_bad;
  pm_mode_e mode;

  pms_supply_mon u_sup (
    .clk(clk), .rst_n(rst_n), .sup_above_on(sup_above_on), .sup_above_off(sup_above_off),
    .off_now(off_now), .thr_pin_o(thr_pin_o), .thr_pin_oe(thr_pin_oe)
  );

  pms_sor_gen #(.SOR_LEN(SOR_LEN)) u_sor (
    .clk(clk), .rst_n(rst_n), .off_now(off_now), .sor_trig(sor_trig), .sor_active(sor_active)
  );

  pms_mode_fsm #(.NWAKE(NWAKE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .off_now(off_now), .sup_above_on(sup_above_on),
    .sor_active(sor_active), .hw_rst_pin(hw_rst_pin), .sw_rst_cmd(sw_rst_cmd),
    .wdt_expire(wdt_expire), .fly_expire(fly_expire), .st_expire(st_expire),
    .cpu_tmr_wake(cpu_tmr_wake), .ext_irq_wake(ext_irq_wake), .wake_pin_n(wake_pin_n),
    .sleep_req(sleep_req), .sleep_code(sleep_code), .xto_req(xto_req), .xto_ready(xto_ready),
    .radio_cfg_done(radio_cfg_done), .mode_q(mode), .sor_trig(sor_trig),
    .wake_keep(wake_keep), .wake_st(wake_st), .req_accept(req_accept), .req_bad(req_bad),
    .clk_sel_xto(clk_sel_xto), .radio_cfg_lost(radio_cfg_lost), .req_err(req_err)
  );

  pms_dom_ctrl u_dom (
    .mode(mode), .sor_active(sor_active), .cpu_stop(cpu_stop),
    .dig_pwr_en(dig_pwr_en), .fly_pwr_en(fly_pwr_en), .ram_on_aon(ram_on_aon)
  );

  assign mode_o    = 3'(mode);
  assign sor_pulse = sor_active;
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_above_off,
  input logic       hw_rst_pin,
  input logic       sw_rst_cmd,
  input logic       wdt_expire,
  input logic       fly_expire,
  input logic [2:0] mode_o,
  input logic       sor_pulse,
  input logic       clk_sel_xto,
  input logic       cpu_stop,
  input logic       dig_pwr_en,
  input logic       fly_pwr_en,
  input logic       ram_on_aon,
  input logic       radio_cfg_lost,
  input logic       thr_pin_oe,
  input logic       req_err,
  input logic       wake_keep,
  input logic       wake_st,
  input logic       req_accept,
  input logic       req_bad
);
  a_r1_off_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_above_off |=> (mode_o == 3'd0 && !sor_pulse));

  a_r2_source_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_above_off && mode_o != 3'd0 && (hw_rst_pin || sw_rst_cmd || wdt_expire || fly_expire))
    |=> (sor_pulse && mode_o == 3'd1));

  a_r3_pulse_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    sor_pulse |-> (!clk_sel_xto && !radio_cfg_lost && mode_o == 3'd1));

  a_r4_standby_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
    wake_keep |=> (mode_o == 3'd1 && $stable(clk_sel_xto)));

  a_r5_short_drops_radio: assert property (@(posedge clk) disable iff (!rst_n)
    wake_st |=> (mode_o == 3'd1 && radio_cfg_lost && !clk_sel_xto));

  a_r7_deep_domains: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |-> (!dig_pwr_en && !fly_pwr_en && ram_on_aon && cpu_stop));

  a_r7_pulse_stops_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    sor_pulse |-> cpu_stop);

  a_r8_accept_in_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (mode_o == 3'd1 && !sor_pulse));

  a_r9_no_error_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sor_pulse |=> !req_err);

  a_r10_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |=> (req_err && mode_o == 3'd1));

  a_r11_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_above_off |=> !thr_pin_oe);
endmodule

bind pwr_mode_seq pms_checker u_pms_chk (
  .clk(clk), .rst_n(rst_n), .sup_above_off(sup_above_off), .hw_rst_pin(hw_rst_pin),
  .sw_rst_cmd(sw_rst_cmd), .wdt_expire(wdt_expire), .fly_expire(fly_expire),
  .mode_o(mode_o), .sor_pulse(sor_pulse), .clk_sel_xto(clk_sel_xto), .cpu_stop(cpu_stop),
  .dig_pwr_en(dig_pwr_en), .fly_pwr_en(fly_pwr_en), .ram_on_aon(ram_on_aon),
  .radio_cfg_lost(radio_cfg_lost), .thr_pin_oe(thr_pin_oe), .req_err(req_err),
  .wake_keep(wake_keep), .wake_st(wake_st), .req_accept(req_accept), .req_bad(req_bad)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  localparam int SOR_LEN = 4;
  localparam int NWAKE   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_above_on = 0, sup_above_off = 0, hw_rst_pin = 0, sw_rst_cmd = 0;
  logic wdt_expire = 0, fly_expire = 0, st_expire = 0, cpu_tmr_wake = 0, ext_irq_wake = 0;
  logic [NWAKE-1:0] wake_pin_n = '1;
  logic sleep_req = 0, xto_req = 0, xto_ready = 0, radio_cfg_done = 0;
  logic [2:0] sleep_code = 3'd0;
  logic [2:0] mode_o;
  logic sor_pulse, clk_sel_xto, cpu_stop, dig_pwr_en, fly_pwr_en, ram_on_aon;
  logic radio_cfg_lost, thr_pin_o, thr_pin_oe, req_err;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.SOR_LEN(SOR_LEN), .NWAKE(NWAKE)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_len(input string req);
    int n = 0;
    while (sor_pulse && n < 50) begin n++; tick(); end
    chk(req, n, SOR_LEN);
  endtask

  task automatic sleep(input logic [2:0] code);
    sleep_req = 1; sleep_code = code; tick(); sleep_req = 0;
  endtask

  task automatic t_reset_state();
    chk("R1 reset mode", mode_o, 0);
    chk("R1 reset pulse", sor_pulse, 0);
    chk("R11 reset pin oe", thr_pin_oe, 0);
  endtask

  task automatic t_power_up();
    sup_above_off = 1; tick();
    chk("R1 stays off below turn-on", mode_o, 0);
    chk("R11 tri-state before turn-on", thr_pin_oe, 0);
    hw_rst_pin = 1; tick(); hw_rst_pin = 0;
    chk("R1 reset ignored in off", sor_pulse, 0);
    sup_above_on = 1; tick();
    chk("R1 exit to cpu", mode_o, 1);
    chk("R11 pin driven", thr_pin_oe, 1);
    chk("R11 pin high", thr_pin_o, 1);
    chk("R7 cpu stopped in pulse", cpu_stop, 1);
    pulse_len("R3 power-up pulse length");
    chk("R7 cpu runs after pulse", cpu_stop, 0);
    sup_above_on = 0; tick();
    chk("R11 pin low under turn-on", thr_pin_o, 0);
    chk("R11 pin still driven", thr_pin_oe, 1);
    chk("R1 cpu kept above turn-off", mode_o, 1);
  endtask

  task automatic t_clock();
    xto_req = 1; tick();
    chk("R12 no switch without ready", clk_sel_xto, 0);
    xto_ready = 1; tick(); xto_req = 0;
    chk("R12 switch to crystal", clk_sel_xto, 1);
  endtask

  task automatic t_standby();
    sleep(3'd2);
    chk("R8 enter standby", mode_o, 2);
    chk("R7 standby digital on", dig_pwr_en, 1);
    chk("R7 standby ram not aon", ram_on_aon, 0);
    chk("R7 standby cpu stop", cpu_stop, 1);
    wake_pin_n = 2'b10; st_expire = 1; tick(); wake_pin_n = '1; st_expire = 0;
    chk("R6 wake pin ignored in standby", mode_o, 2);
    sleep(3'd3);
    chk("R8 request ignored outside cpu", mode_o, 2);
    ext_irq_wake = 1; tick(); ext_irq_wake = 0;
    chk("R4 irq resumes cpu", mode_o, 1);
    chk("R4 clock kept", clk_sel_xto, 1);
    chk("R4 no reset", sor_pulse, 0);
    sleep(3'd2);
    wdt_expire = 1; tick(); wdt_expire = 0;
    chk("R2 watchdog in standby resets", sor_pulse, 1);
    chk("R3 clock back to rc", clk_sel_xto, 0);
    pulse_len("R3 watchdog pulse length");
  endtask

  task automatic t_short();
    xto_req = 1; tick(); xto_req = 0;
    chk("R12 crystal again", clk_sel_xto, 1);
    sleep(3'd3);
    chk("R8 enter short sleep", mode_o, 3);
    chk("R12 short entry drops crystal", clk_sel_xto, 0);
    chk("R7 short digital off", dig_pwr_en, 0);
    chk("R7 short ram aon", ram_on_aon, 1);
    chk("R7 short flywheel on", fly_pwr_en, 1);
    cpu_tmr_wake = 1; tick(); cpu_tmr_wake = 0;
    chk("R6 cpu timer ignored in short", mode_o, 3);
    st_expire = 1; tick(); st_expire = 0;
    chk("R5 short wake to cpu", mode_o, 3'd1);
    chk("R5 radio lost", radio_cfg_lost, 1);
    chk("R5 no reset on short wake", sor_pulse, 0);
    radio_cfg_done = 1; tick(); radio_cfg_done = 0;
    chk("R5 radio cleared by cpu", radio_cfg_lost, 0);
    sleep(3'd3); st_expire = 1; tick(); st_expire = 0;
    chk("R5 radio lost again", radio_cfg_lost, 1);
    sw_rst_cmd = 1; tick(); sw_rst_cmd = 0;
    chk("R2 software reset", sor_pulse, 1);
    chk("R3 reset clears radio flag", radio_cfg_lost, 0);
    // request during the pulse
    sleep(3'd5);
    chk("R9 request ignored in pulse", mode_o, 1);
    chk("R9 no error in pulse", req_err, 0);
    while (sor_pulse) tick();
  endtask

  task automatic t_bad_codes();
    sleep(3'd6);
    chk("R10 error flag", req_err, 1);
    chk("R10 mode unchanged", mode_o, 1);
    tick();
    chk("R10 error one cycle", req_err, 0);
    sleep(3'd0);
    chk("R10 code zero flagged", req_err, 1);
    chk("R10 code zero no change", mode_o, 1);
  endtask

  task automatic t_flywheel();
    sleep(3'd4);
    chk("R8 enter flywheel", mode_o, 4);
    chk("R7 flywheel domain", fly_pwr_en, 1);
    chk("R7 flywheel digital off", dig_pwr_en, 0);
    ext_irq_wake = 1; tick(); ext_irq_wake = 0;
    chk("R6 irq ignored in flywheel", mode_o, 4);
    wake_pin_n = 2'b01; tick(); wake_pin_n = '1;
    chk("R6 wake pin resets flywheel", sor_pulse, 1);
    chk("R6 flywheel wake to cpu", mode_o, 1);
    while (sor_pulse) tick();
  endtask

  task automatic t_deep();
    sleep(3'd5);
    chk("R8 enter deep", mode_o, 5);
    chk("R7 deep flywheel off", fly_pwr_en, 0);
    chk("R7 deep ram aon", ram_on_aon, 1);
    st_expire = 1; tick(); st_expire = 0;
    chk("R6 short timer ignored in deep", mode_o, 5);
    wdt_expire = 1; tick(); wdt_expire = 0;
    chk("R2 watchdog leaves deep", sor_pulse, 1);
    chk("R2 deep wake to cpu", mode_o, 1);
    while (sor_pulse) tick();
    sleep(3'd5);
    fly_expire = 1; tick(); fly_expire = 0;
    chk("R2 flywheel timeout resets", sor_pulse, 1);
    while (sor_pulse) tick();
  endtask

  task automatic t_hw_hold();
    hw_rst_pin = 1; tick(); tick(); tick(); hw_rst_pin = 0;
    chk("R2 hardware pin resets", sor_pulse, 1);
    pulse_len("R3 pulse counted from last trigger");
  endtask

  task automatic t_power_fail();
    sup_above_off = 0; tick();
    chk("R1 power fail to off", mode_o, 0);
    chk("R11 pin released", thr_pin_oe, 0);
    chk("R7 off cpu stop", cpu_stop, 1);
    sup_above_off = 1; tick();
    chk("R1 off held below turn-on", mode_o, 0);
    chk("R11 stays tri-state", thr_pin_oe, 0);
    sup_above_on = 1; tick();
    chk("R1 re-entry resets", sor_pulse, 1);
  endtask

  initial begin
    repeat (3) tick();
    t_reset_state();
    rst_n = 1; tick();
    t_power_up();
    t_clock();
    t_standby();
    t_short();
    t_bad_codes();
    t_flywheel();
    t_deep();
    t_hw_hold();
    t_power_fail();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule